// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block makes every individual bit of a 1 MiB backing memory region addressable as its own 32-bit word. The bridge sits behind a 32 MiB alias window. A requester issues an ordinary load or store of 1, 2 or 4 bytes to an alias location. The bridge works out which backing byte and which bit the location stands for, and then performs the matching access on a second bus that faces the backing memory.

A load returns the chosen bit in bit 0 of the response, with every other bit zero. A store sets or clears that one bit and leaves its neighbours alone. To do this, the bridge reads the backing bytes, changes the one bit according to bit 0 of the store data, and writes the same bytes back.

The requester is held (ready low) until the whole exchange has finished. An error from either backing phase is passed back with the response. If the read phase of a store fails, the write-back is not issued. The backing base address is a parameter, so one copy can serve a memory region and another copy can serve a peripheral region.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is high, and in the first cycle after it, reqReady is 1, and memReq and rspValid are 0.
- R2: The backing address is BASE_ADDR OR (reqAddr[24:0] >> 5), rounded down to a multiple of reqSize. reqAddr bits 31..25 have no effect. memAddr is held stable while memReq waits for memGnt.
- R3: reqSize is a byte count. The values 1, 2 and 4 are accepted and forwarded unchanged on memSize. Any other value gets rspValid with rspErr=1 and rspRdata=0 in the cycle after acceptance, and no backing request is made.
- R4: The selected bit index is reqAddr[6:2] AND (8*reqSize-1). Backing data uses little-endian byte lanes: byte k from the aligned address is in memRdata/memWdata bits [8k+7:8k], so index i is data bit i. Only the low reqSize bytes are significant.
- R5: A load makes one backing read. It returns the selected bit in rspRdata[0], with rspRdata[31:1] = 0 and rspErr = 0.
- R6: A store reads the backing bytes, then issues one write (memWrite=1) to the same address and size. The write data equals the read data with the selected bit set to reqWdata[0]. The store response has rspRdata = 0.
- R7: An error on the backing read ends the access with rspErr=1 and rspRdata=0. For a store, no write-back request is issued.
- R8: An error on the write-back response is reported as rspErr=1.
- R9: reqReady is 1 only when the bridge is idle. A request is taken when reqValid and reqReady are both 1. rspValid is a one-cycle pulse, and reqReady returns in the cycle after it. memReq stays high until memGnt.
- R10: memReq rises in the cycle after acceptance. The write-back request follows in the cycle after a good read response. rspValid follows in the cycle after the last backing response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Requester presents an access |
| reqReady | output | 1 | Bridge idle and able to take an access |
| reqAddr | input | 32 | Alias address (low 25 bits used) |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 3 | Access size in bytes (1, 2 or 4) |
| reqWdata | input | 32 | Store data; bit 0 is the new bit value |
| rspValid | output | 1 | One-cycle response strobe |
| rspRdata | output | 32 | Load result (selected bit in bit 0) |
| rspErr | output | 1 | Access failed |
| memReq | output | 1 | Backing request pending |
| memGnt | input | 1 | Backing bus takes the request |
| memWrite | output | 1 | Backing request is a write |
| memAddr | output | 32 | Aligned backing byte address |
| memSize | output | 3 | Backing byte count |
| memWdata | output | 32 | Backing write data, little-endian lanes |
| memRspValid | input | 1 | Backing response strobe |
| memRdata | input | 32 | Backing read data, little-endian lanes |
| memErr | input | 1 | Backing response reports an error |

## Verification
The hardest paths to reach from the ports are the error branches of a store: a failure of the read phase must suppress the write-back, and a failure of the write-back itself must still be reported. The bench's backing-memory agent can inject an error independently into the read phase or the write phase of any transaction. It also varies the grant delay and the response delay, so that the held request and the waiting states are exercised with stalls. Because alias offsets are drawn from a narrow range, stores and later loads fall on the same backing bytes. Unused upper lanes carry a filler pattern, which exposes any byte that is misplaced or picked from the wrong lane.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ISSUE,
    S_RD_WAIT,
    S_WR_ISSUE,
    S_WR_WAIT,
    S_RESP
  } bbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch the incoming access
    logic capRead;  // latch backing read data
    logic setErr;   // a backing phase reported an error
  } bbCtl_t;

endpackage

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_BITS = 25,
  parameter int SIZE_W = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  bbCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memErr,
  output logic              sizeOk,
  output logic              opWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SIZE_W-1:0] memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);

  localparam int BYTES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(BYTES);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int WORD_SH = LANE_W;          // alias word stride
  localparam int XL_SH   = WORD_SH + 3;     // alias bytes per backing byte

  // ---------------- size decode ----------------
  logic [LANE_W:0] sizeHit;
  for (genvar g = 0; g <= LANE_W; g++) begin : g_size
    assign sizeHit[g] = (reqSize == SIZE_W'(1 << g));
  end
  assign sizeOk = |sizeHit;

  // ---------------- address translation ----------------
  logic [WIN_BITS-1:0] winOff;
  logic [ADDR_W-1:0]   byteOff;
  logic [ADDR_W-1:0]   rawAddr;
  logic [ADDR_W-1:0]   alignMask;
  logic [ADDR_W-1:0]   bkAddr;

  assign winOff    = reqAddr[WIN_BITS-1:0];
  assign byteOff   = ADDR_W'(winOff) >> XL_SH;
  assign rawAddr   = BASE_ADDR | byteOff;
  assign alignMask = ~(ADDR_W'(reqSize) - ADDR_W'(1));
  assign bkAddr    = rawAddr & alignMask;

  // ---------------- bit index ----------------
  logic [BIT_W-1:0] wordIdx;
  logic [BIT_W-1:0] idxMask;
  logic [BIT_W-1:0] bitIdx;

  assign wordIdx = reqAddr[WORD_SH +: BIT_W];
  assign idxMask = BIT_W'((32'(reqSize) << 3) - 32'd1);
  assign bitIdx  = wordIdx & idxMask;

  logic unusedReq;
  assign unusedReq = ^{reqAddr[ADDR_W-1:WIN_BITS], reqAddr[WORD_SH-1:0],
                       reqWdata[DATA_W-1:1]};

  // ---------------- registers ----------------
  logic [ADDR_W-1:0] addrQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [BIT_W-1:0]  idxQ;
  logic              wbitQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rspDataQ;
  logic              errQ;

  // merge of new bit into fetched data
  logic [DATA_W-1:0] merged;
  for (genvar g = 0; g < DATA_W; g++) begin : g_merge
    assign merged[g] = (idxQ == BIT_W'(g)) ? wbitQ : memRdata[g];
  end

  logic selBit;
  assign selBit = memRdata[idxQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ    <= '0;
      sizeQ    <= '0;
      idxQ     <= '0;
      wbitQ    <= 1'b0;
      writeQ   <= 1'b0;
      wdataQ   <= '0;
      rspDataQ <= '0;
      errQ     <= 1'b0;
    end else begin
      if (ctl.capReq) begin
        addrQ    <= bkAddr;
        sizeQ    <= reqSize;
        idxQ     <= bitIdx;
        wbitQ    <= reqWdata[0];
        writeQ   <= reqWrite;
        rspDataQ <= '0;
        errQ     <= ~sizeOk;
      end
      if (ctl.capRead) begin
        wdataQ   <= merged;
        rspDataQ <= (!writeQ && !memErr) ? DATA_W'(selBit) : '0;
      end
      if (ctl.setErr) begin
        errQ <= 1'b1;
      end
    end
  end

  assign opWrite  = writeQ;
  assign memAddr  = addrQ;
  assign memSize  = sizeQ;
  assign memWdata = wdataQ;
  assign rspRdata = rspDataQ;
  assign rspErr   = errQ;

  // backing address is aligned to the access size when data returns (R2)
  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.capRead |-> ((addrQ & (ADDR_W'(sizeQ) - ADDR_W'(1))) == '0));

  // bit index never leaves the significant bytes (R4)
  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.capRead |-> (32'(idxQ) < (32'(sizeQ) << 3)));

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  input  logic   sizeOk,
  input  logic   opWrite,
  input  logic   memGnt,
  input  logic   memRspValid,
  input  logic   memErr,
  output logic   reqReady,
  output logic   rspValid,
  output logic   memReq,
  output logic   memWrite,
  output bbCtl_t ctl
);

  bbState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:     if (reqValid) stateNext = sizeOk ? S_RD_ISSUE : S_RESP;
      S_RD_ISSUE: if (memGnt) stateNext = S_RD_WAIT;
      S_RD_WAIT:  if (memRspValid) stateNext = (memErr || !opWrite) ? S_RESP : S_WR_ISSUE;
      S_WR_ISSUE: if (memGnt) stateNext = S_WR_WAIT;
      S_WR_WAIT:  if (memRspValid) stateNext = S_RESP;
      S_RESP:     stateNext = S_IDLE;
      default:    stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);
  assign memReq   = (state == S_RD_ISSUE) || (state == S_WR_ISSUE);
  assign memWrite = (state == S_WR_ISSUE);

  always_comb begin
    ctl.capReq  = (state == S_IDLE) && reqValid;
    ctl.capRead = (state == S_RD_WAIT) && memRspValid;
    ctl.setErr  = ((state == S_RD_WAIT) || (state == S_WR_WAIT)) && memRspValid && memErr;
  end

  // idle is exclusive with any pending backing request or response (R9)
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (!memReq && !rspValid));

  // a waiting backing request keeps its direction until granted (R9)
  p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memGnt) |=> (memReq && $stable(memWrite)));

  // response is a single pulse followed by idle (R9)
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> (!rspValid && reqReady));

  // write-back only follows an error-free read response (R7)
  p_wb_after_ok_read_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(memWrite) |-> $past(memRspValid && !memErr));

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_BITS = 25,
  parameter int SIZE_W = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              memReq,
  input  logic              memGnt,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SIZE_W-1:0] memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memErr
);

  bbCtl_t ctl;
  logic   sizeOk;
  logic   opWrite;

  bb_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .sizeOk      (sizeOk),
    .opWrite     (opWrite),
    .memGnt      (memGnt),
    .memRspValid (memRspValid),
    .memErr      (memErr),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .memReq      (memReq),
    .memWrite    (memWrite),
    .ctl         (ctl)
  );

  bb_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WIN_BITS  (WIN_BITS),
    .SIZE_W    (SIZE_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memErr   (memErr),
    .sizeOk   (sizeOk),
    .opWrite  (opWrite),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .memWdata (memWdata),
    .rspRdata (rspRdata),
    .rspErr   (rspErr)
  );

  // only bit 0 of a response can be non-zero (R5)
  p_rsp_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspRdata[DATA_W-1:1] == '0));

  // backing address holds while the request waits (R2)
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memGnt) |=> $stable(memAddr));

  // write-back differs from fetched data in at most one bit (R6)
  p_one_bit_change_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(memReq && memWrite) |-> ($countones(memWdata ^ $past(memRdata)) <= 1));

endmodule

// File: tb/bitband_bridge_tb.sv
`timescale 1ns/1ps
module bitband_bridge_tb;

  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqAddr;
  logic        reqWrite;
  logic [2:0]  reqSize;
  logic [31:0] reqWdata;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        rspErr;
  logic        memReq;
  logic        memGnt;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [2:0]  memSize;
  logic [31:0] memWdata;
  logic        memRspValid;
  logic [31:0] memRdata;
  logic        memErr;

  always #4 clk = ~clk;

  bitband_bridge #(.BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
    .memReq(memReq), .memGnt(memGnt), .memWrite(memWrite),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata),
    .memRspValid(memRspValid), .memRdata(memRdata), .memErr(memErr)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural backing store
  logic [7:0] store [int unsigned];

  function automatic logic [7:0] rdByte(input int unsigned a);
    if (store.exists(a)) return store[a];
    return 8'((a * 37) + 11);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // one access, stepped one clock at a time with expected outputs per cycle
  task automatic txn(input logic [31:0] addr, input logic [2:0] sz, input logic wr,
                     input logic wb, input int gd, input int rdl,
                     input logic eRd, input logic eWr);
    logic [31:0] a, d, nd, mask, expData;
    int idx;
    logic expErr;
    chk("R9", "reqReady idle", 32'(reqReady), 1);
    reqValid = 1; reqAddr = addr; reqSize = sz; reqWrite = wr;
    reqWdata = {31'h2AAA_5555, wb};
    @(negedge clk);
    reqValid = 0; reqAddr = 32'hFFFF_FFFF; reqSize = 3'd7; reqWrite = ~wr; reqWdata = '1;
    if (!(sz == 1 || sz == 2 || sz == 4)) begin
      chk("R3", "bad size rspValid", 32'(rspValid), 1);
      chk("R3", "bad size rspErr", 32'(rspErr), 1);
      chk("R3", "bad size rspRdata", rspRdata, 0);
      chk("R3", "bad size no memReq", 32'(memReq), 0);
      @(negedge clk);
      chk("R9", "ready after bad size", 32'(reqReady), 1);
      chk("R3", "no memReq after bad size", 32'(memReq), 0);
      return;
    end
    a = (BASE | ((addr & 32'h01FF_FFFF) >> 5)) & ~(32'(sz) - 1);
    idx = int'((addr >> 2) & ((32'(sz) * 8) - 1));
    mask = (sz == 4) ? 32'hFFFF_FFFF : (sz == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
    for (int k = 0; k < 4; k++)
      d[8*k +: 8] = (k < int'(sz)) ? rdByte(a + k) : 8'hA5;
    // read phase
    for (int i = 0; i <= gd; i++) begin
      chk("R10", "read memReq", 32'(memReq), 1);
      chk("R5", "read memWrite", 32'(memWrite), 0);
      chk("R2", "memAddr", memAddr, a);
      chk("R3", "memSize", 32'(memSize), 32'(sz));
      chk("R9", "busy", 32'(reqReady), 0);
      chk("R9", "no rsp yet", 32'(rspValid), 0);
      if (i == gd) memGnt = 1;
      @(negedge clk);
      memGnt = 0;
    end
    for (int i = 0; i <= rdl; i++) begin
      chk("R9", "memReq dropped after grant", 32'(memReq), 0);
      chk("R9", "no rsp in read wait", 32'(rspValid), 0);
      if (i == rdl) begin memRspValid = 1; memRdata = d; memErr = eRd; end
      @(negedge clk);
      memRspValid = 0; memRdata = 32'h5A5A_C3C3; memErr = 0;
    end
    expErr = eRd;
    expData = 0;
    if (!wr && !eRd) expData = 32'(d[idx]);
    if (wr && !eRd) begin
      nd = d;
      nd[idx] = wb;
      for (int i = 0; i <= gd; i++) begin
        chk("R10", "write-back memReq", 32'(memReq), 1);
        chk("R6", "write-back memWrite", 32'(memWrite), 1);
        chk("R6", "write-back memAddr", memAddr, a);
        chk("R6", "write-back memSize", 32'(memSize), 32'(sz));
        chk("R6", "write-back data", memWdata & mask, nd & mask);
        chk("R9", "no rsp in write issue", 32'(rspValid), 0);
        if (i == gd) memGnt = 1;
        @(negedge clk);
        memGnt = 0;
      end
      for (int i = 0; i <= rdl; i++) begin
        chk("R9", "memReq low in write wait", 32'(memReq), 0);
        chk("R9", "no rsp in write wait", 32'(rspValid), 0);
        if (i == rdl) begin memRspValid = 1; memErr = eWr; memRdata = 32'h0BAD_F00D; end
        @(negedge clk);
        memRspValid = 0; memErr = 0;
      end
      if (!eWr) for (int k = 0; k < int'(sz); k++) store[a + k] = nd[8*k +: 8];
      expErr = eWr;
    end
    chk("R10", "rspValid", 32'(rspValid), 1);
    chk("R7", "no further memReq", 32'(memReq), 0);
    chk(eWr && wr ? "R8" : (eRd ? "R7" : "R5"), "rspErr", 32'(rspErr), 32'(expErr));
    chk(wr ? "R6" : "R5", "rspRdata", rspRdata, expData);
    @(negedge clk);
    chk("R9", "rsp pulse ends", 32'(rspValid), 0);
    chk("R9", "ready returns", 32'(reqReady), 1);
    chk("R7", "idle no memReq", 32'(memReq), 0);
  endtask

  // read a bit back through the bridge and compare with an expected value
  task automatic readBit(input logic [31:0] addr, input logic [2:0] sz, input string req);
    txn(addr, sz, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; reqValid = 0; reqAddr = 0; reqWrite = 0; reqSize = 3'd4; reqWdata = 0;
    memGnt = 0; memRspValid = 0; memRdata = 0; memErr = 0;
    repeat (2) @(negedge clk);
    chk("R1", "reset reqReady", 32'(reqReady), 1);
    chk("R1", "reset memReq", 32'(memReq), 0);
    chk("R1", "reset rspValid", 32'(rspValid), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "post-reset reqReady", 32'(reqReady), 1);
    chk("R1", "post-reset memReq", 32'(memReq), 0);

    // R5/R4: loads of each size, differing upper alias bits (R2)
    txn(32'h2200_0000, 3'd4, 0, 0, 0, 0, 0, 0);
    txn(32'h2200_007C, 3'd4, 0, 0, 0, 0, 0, 0);
    txn(32'hFE00_0134, 3'd2, 0, 0, 1, 0, 0, 0);
    txn(32'h2200_02A8, 3'd1, 0, 0, 0, 2, 0, 0);
    txn(32'h23FF_FFFC, 3'd4, 0, 0, 0, 0, 0, 0);   // top of window
    // R6: stores set and clear, then read back
    txn(32'h2200_0044, 3'd1, 1, 1, 0, 0, 0, 0);
    readBit(32'h2200_0044, 3'd1, "R6");
    txn(32'h2200_0044, 3'd4, 1, 0, 2, 1, 0, 0);
    readBit(32'h2200_0044, 3'd2, "R6");
    txn(32'h2200_00F8, 3'd2, 1, 1, 3, 3, 0, 0);
    // R7: read error on load and on store (store must not write back)
    txn(32'h2200_0010, 3'd4, 0, 0, 0, 0, 1, 0);
    txn(32'h2200_0010, 3'd4, 1, 1, 1, 1, 1, 0);
    readBit(32'h2200_0010, 3'd4, "R7");
    // R8: write-back error, backing stays unchanged
    txn(32'h2200_0020, 3'd1, 1, 1, 0, 1, 0, 1);
    readBit(32'h2200_0020, 3'd1, "R8");
    // R3: unsupported sizes
    txn(32'h2200_0000, 3'd3, 0, 0, 0, 0, 0, 0);
    txn(32'h2200_0000, 3'd0, 1, 1, 0, 0, 0, 0);
    txn(32'h2200_0000, 3'd7, 0, 0, 0, 0, 0, 0);

    // mixed traffic over a small backing range
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [2:0] s;
      r = $urandom;
      s = (r[1:0] == 2'd0) ? 3'd1 : (r[1:0] == 2'd1) ? 3'd2 : (r[1:0] == 2'd2) ? 3'd4 : 3'd5;
      txn({r[31:25], 15'h0, r[9:0]}, s, r[12], r[13], int'(r[15:14]), int'(r[17:16]),
          (r[22:19] == 0), (r[26:23] == 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule